// File: doc/BRIEF.md
# Interleaved Reed-Solomon Row Encoder

This block adds forward error correction to one transport frame row at a time. A row is 4080 bytes. It moves through the block as 510 words of 64 bits, eight bytes per clock. The row holds sixteen RS(255,239) codewords, interleaved one byte each. Byte column `c` belongs to codeword `c mod 16`. The first 3824 columns, which are words 0 to 477, carry information. The last 256 columns, which are words 478 to 509, are reserved for parity. The encoder keeps a separate parity register set for each codeword. It feeds each information byte into its codeword's register set on the fly. When the reserved words arrive, it overwrites them with the computed parity.

A start-of-row strobe marks word 0 of a row, and a valid strobe qualifies each word. Idle cycles may fall anywhere in a row. The outputs follow the inputs by exactly one clock. Two static controls change what appears in the parity columns:
- The stuff control writes all-zero bytes there instead of parity.
- The bypass control leaves the whole stream untouched.

A row start that arrives before the current row has completed abandons that row and starts a new one. It also sets a sticky error flag.

Top module: `rs_row_enc`

## Requirements
- R1: Byte lane k of a word is bits [8k+7:8k], and it holds row column 8*w+k, where w is the word index within the row (0 to 509). Column c belongs to codeword c mod 16, and column c is byte number c div 16 of that codeword.
- R2: Each codeword on the output is a systematic RS(255,239) codeword over GF(2^8) with field polynomial 0x11D. Its generator has roots alpha^0 to alpha^15, where alpha = 0x02. The highest-degree parity coefficient comes first, so all sixteen syndromes evaluated at those roots are zero.
- R3: Words 0 to 477 of a row leave the block unchanged.
- R4: When the stuff control is high, words 478 to 509 of a row leave the block as all zeros.
- R5: When bypass is high, every word leaves the block unchanged, including words 478 to 509.
- R6: The data, valid and start outputs follow the corresponding inputs by exactly one clock. Cycles with valid low may occur anywhere in a row; they are not counted as words and are not presented on the output.
- R7: A start strobe during an incomplete row discards that row's parity state, and the strobed word becomes word 0 of a new row. The error output then goes high and stays high until reset.
- R8: During and directly after reset, the valid, start, error and data outputs are all zero.
- R9: A valid word that arrives while no row is open leaves the block unchanged and is not encoded. This covers words before the first start strobe and words after word 509 but before the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word qualifier |
| sof_i | input | 1 | Marks word 0 of a row; only meaningful with valid_i |
| data_i | input | 64 | Input word; lane k is bits [8k+7:8k] |
| fec_dis_i | input | 1 | Static; replaces parity with zero stuff bytes |
| bypass_i | input | 1 | Static; passes all words through unchanged |
| valid_o | output | 1 | Output word qualifier |
| sof_o | output | 1 | Marks output word 0 of a row |
| data_o | output | 64 | Output word |
| err_o | output | 1 | Sticky flag for an early row start |

## Verification
The in-line assertions check several behaviours on every cycle:
- information words and out-of-row words pass through unchanged;
- bypass passes every word unchanged;
- stuff columns are forced to zero;
- the start output is always qualified by valid;
- the error flag, once set, never clears;
- the word counter stays in range and closes after word 509.

Whether the parity bytes are correct cannot be stated as a per-cycle property. The bench shows it instead. It captures whole rows and evaluates all sixteen syndromes of every codeword with its own field arithmetic. It does this for random, gapped, all-zero and restarted rows. The bench's scenarios also show the exact one-clock alignment at a row start and the restart after an abandoned row.

// File: rtl/rs_row_pkg.sv
package rs_row_pkg;
  localparam int RS_N   = 255;
  localparam int RS_K   = 239;
  localparam int RS_PAR = RS_N - RS_K;

  // GF(2^8), field polynomial 0x11D
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return acc;
  endfunction

  // low RS_PAR coefficients of prod (x + alpha^i), i = 0..RS_PAR-1; monic
  function automatic logic [RS_PAR-1:0][7:0] rs_gen();
    logic [RS_PAR:0][7:0] g;
    logic [7:0] root;
    g    = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < RS_PAR; i++) begin
      for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    return g[RS_PAR-1:0];
  endfunction
endpackage

// File: rtl/rs_cw_cell.sv
module rs_cw_cell
  import rs_row_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic [7:0]             byte_i,
  output logic [RS_PAR-1:0][7:0] par_o
);
  localparam logic [RS_PAR-1:0][7:0] GEN = rs_gen();

  logic [RS_PAR-1:0][7:0] par_q, base, step;
  logic [7:0]             fb;

  always_comb begin
    base    = clr_i ? '0 : par_q;
    fb      = byte_i ^ base[RS_PAR-1];
    step[0] = gf_mul(fb, GEN[0]);
    for (int j = 1; j < RS_PAR; j++) step[j] = base[j-1] ^ gf_mul(fb, GEN[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    par_q <= '0;
    else if (en_i)  par_q <= step;
    else if (clr_i) par_q <= '0;

  assign par_o = par_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !en_i) |=> (par_o == '0)); // R7
endmodule

// File: rtl/rs_row_ctrl.sv
module rs_row_ctrl #(
  parameter int ROW_WORDS  = 510,
  parameter int INFO_WORDS = 478,
  localparam int IDX_W     = $clog2(ROW_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             clr_o,
  output logic             info_o,
  output logic             par_o,
  output logic             act_o,
  output logic             err_o
);
  logic [IDX_W-1:0] cnt_q, cur_idx;
  logic             open_q, err_q, start, cur_open;

  assign start    = valid_i & sof_i;
  assign cur_open = start | open_q;
  assign cur_idx  = start ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (valid_i) begin
      if (start && open_q) err_q <= 1'b1;
      if (cur_open) begin
        if (cur_idx == IDX_W'(ROW_WORDS - 1)) begin
          open_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          open_q <= 1'b1;
          cnt_q  <= cur_idx + 1'b1;
        end
      end
    end

  assign idx_o  = cur_idx;
  assign clr_o  = start;
  assign act_o  = valid_i & cur_open;
  assign info_o = act_o & (cur_idx <  IDX_W'(INFO_WORDS));
  assign par_o  = act_o & (cur_idx >= IDX_W'(INFO_WORDS));
  assign err_o  = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && !(valid_i && sof_i)) |=> !err_o); // R7
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < IDX_W'(ROW_WORDS)); // R1
  AST_ROW_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && open_q && cnt_q == IDX_W'(ROW_WORDS - 1)) |=> !open_q); // R9
endmodule

// File: rtl/rs_row_enc.sv
module rs_row_enc
  import rs_row_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int NUM_CW = 16,
  localparam int DATA_W     = LANES * 8,
  localparam int ROW_WORDS  = RS_N * NUM_CW / LANES,
  localparam int INFO_WORDS = RS_K * NUM_CW / LANES,
  localparam int INFO_COLS  = RS_K * NUM_CW,
  localparam int GROUPS     = NUM_CW / LANES,
  localparam int IDX_W      = $clog2(ROW_WORDS),
  localparam int CW_W       = $clog2(NUM_CW),
  localparam int P_W        = $clog2(RS_PAR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fec_dis_i,
  input  logic              bypass_i,
  output logic              valid_o,
  output logic              sof_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic [IDX_W-1:0] word_idx;
  logic             clr, info_act, par_act, row_act;
  logic [NUM_CW-1:0][RS_PAR-1:0][7:0] par_all;

  rs_row_ctrl #(.ROW_WORDS(ROW_WORDS), .INFO_WORDS(INFO_WORDS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sof_i  (sof_i),
    .idx_o  (word_idx),
    .clr_o  (clr),
    .info_o (info_act),
    .par_o  (par_act),
    .act_o  (row_act),
    .err_o  (err_o)
  );

  // codeword j sees lane j%LANES on words whose index mod GROUPS is j/LANES
  for (genvar j = 0; j < NUM_CW; j++) begin : g_cw
    logic en;
    assign en = info_act && ((int'(word_idx) % GROUPS) == (j / LANES));
    rs_cw_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .en_i  (en),
      .byte_i(data_i[8*(j%LANES) +: 8]),
      .par_o (par_all[j])
    );
  end

  logic [LANES-1:0][CW_W-1:0] lane_cw;
  logic [LANES-1:0][P_W-1:0]  lane_p;
  logic [LANES-1:0][7:0]      lane_par;
  logic [DATA_W-1:0]          out_d;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_cw[k]  = CW_W'((int'(word_idx) * LANES + k) % NUM_CW);
      lane_p[k]   = P_W'(RS_PAR - 1 - (int'(word_idx) * LANES + k - INFO_COLS) / NUM_CW);
      lane_par[k] = fec_dis_i ? 8'h00 : par_all[lane_cw[k]][lane_p[k]];
      out_d[8*k +: 8] = (par_act && !bypass_i) ? lane_par[k] : data_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      sof_o   <= valid_i & sof_i;
      if (valid_i) data_o <= out_d;
    end

  AST_INFO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    info_act |=> (data_o == $past(data_i))); // R3
  AST_STUFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_act && fec_dis_i && !bypass_i) |=> (data_o == '0)); // R4
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bypass_i) |=> (data_o == $past(data_i))); // R5
  AST_SOF_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o); // R6
  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !row_act) |=> (data_o == $past(data_i))); // R9
endmodule

// File: tb/rs_row_enc_tb.sv
module rs_row_enc_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, sof = 1'b0, fec_dis = 1'b0, bypass = 1'b0;
  logic [63:0] din = '0;
  logic        valid_o, sof_o, err_o;
  logic [63:0] data_o;

  int n_chk = 0, n_bad = 0, cap_n = 0;
  bit done = 0;
  logic [63:0] in_row [0:509];
  logic [63:0] cap    [0:1023];

  always #2 clk = ~clk;

  rs_row_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .data_i(din),
    .fec_dis_i(fec_dis), .bypass_i(bypass),
    .valid_o(valid_o), .sof_o(sof_o), .data_o(data_o), .err_o(err_o)
  );

  always @(negedge clk) if (rst_n && valid_o) begin
    if (sof_o) cap_n = 0;
    if (cap_n < 1024) cap[cap_n] = data_o;
    cap_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) if (a[i]) acc = acc ^ (16'(b) << i);
    for (int i = 15; i >= 8; i--) if (acc[i]) acc = acc ^ (16'h11D << (i - 8));
    return acc[7:0];
  endfunction

  // R1 column mapping, R2 zero syndromes
  function automatic logic [7:0] syndrome(input int j, input int r);
    logic [7:0] a, s;
    int col;
    a = 8'h01;
    for (int i = 0; i < r; i++) a = tb_mul(a, 8'h02);
    s = '0;
    for (int c = 0; c < 255; c++) begin
      col = c * 16 + j;
      s = tb_mul(s, a) ^ cap[col / 8][8 * (col % 8) +: 8];
    end
    return s;
  endfunction

  task automatic send_row(input bit gaps);
    for (int w = 0; w < 510; w++) begin
      @(negedge clk);
      valid = 1'b1; sof = (w == 0); din = in_row[w];
      if (gaps && (w % 37 == 5)) begin
        @(negedge clk);
        valid = 1'b0; sof = 1'b0; din = '1;
      end
    end
    @(negedge clk);
    valid = 1'b0; sof = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_row(input string req, input bit stuff);
    int bad_w;
    chk(cap_n == 510, "R6", "word count", 64'(cap_n), 64'd510);
    bad_w = -1;
    for (int w = 0; w < 478; w++) if (bad_w < 0 && cap[w] !== in_row[w]) bad_w = w;
    chk(bad_w < 0, "R3", "info word", bad_w < 0 ? '0 : cap[bad_w], bad_w < 0 ? '0 : in_row[bad_w]);
    if (stuff) begin
      for (int w = 478; w < 510; w++) chk(cap[w] == '0, "R4", "stuff word", cap[w], '0);
    end else begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] s;
        s = '0;
        for (int r = 0; r < 16; r++) s = s | syndrome(j, r);
        chk(s == '0, req, $sformatf("syndromes cw%0d", j), 64'(s), '0);
      end
    end
  endtask

  task automatic fill_random();
    for (int w = 0; w < 510; w++) in_row[w] = {$urandom, $urandom};
  endtask

  task automatic t_reset();
    chk(valid_o == 0 && sof_o == 0 && err_o == 0, "R8", "reset flags",
        {61'd0, valid_o, sof_o, err_o}, '0);
    chk(data_o == '0, "R8", "reset data", data_o, '0);
  endtask

  task automatic t_idle(input string what);
    for (int i = 0; i < 4; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      @(negedge clk); valid = 1'b1; sof = 1'b0; din = d;
      @(negedge clk); valid = 1'b0;
      chk(valid_o && !sof_o && data_o == d, "R9", what, data_o, d);
    end
  endtask

  task automatic t_random_row();
    fill_random(); send_row(0); check_row("R2", 0);
    chk(err_o == 0, "R7", "no error on full row", 64'(err_o), '0);
  endtask

  task automatic t_gap_row();
    for (int w = 0; w < 510; w++) in_row[w] = {8{w[7:0] ^ 8'h5A}} + 64'(w);
    send_row(1); check_row("R6", 0);
  endtask

  task automatic t_zero_row();
    int nz;
    for (int w = 0; w < 510; w++) in_row[w] = '1; // parity slots overwritten
    for (int w = 0; w < 478; w++) in_row[w] = '0;
    send_row(0);
    nz = 0;
    for (int w = 0; w < 510; w++) if (cap[w] != '0) nz++;
    chk(nz == 0, "R2", "all-zero info gives zero parity", 64'(nz), '0);
  endtask

  task automatic t_stuff();
    fill_random(); fec_dis = 1'b1; send_row(0); fec_dis = 1'b0;
    check_row("R4", 1);
  endtask

  task automatic t_bypass();
    int bad_w;
    fill_random(); bypass = 1'b1; send_row(0); bypass = 1'b0;
    bad_w = -1;
    for (int w = 0; w < 510; w++) if (bad_w < 0 && cap[w] !== in_row[w]) bad_w = w;
    chk(bad_w < 0 && cap_n == 510, "R5", "bypass row", bad_w < 0 ? '0 : cap[bad_w],
        bad_w < 0 ? '0 : in_row[bad_w]);
  endtask

  task automatic t_early();
    logic [63:0] d0;
    d0 = 64'h0123_4567_89AB_CDEF;
    @(negedge clk); valid = 1'b1; sof = 1'b1; din = d0;
    @(negedge clk); valid = 1'b0; sof = 1'b0;
    chk(valid_o && sof_o && data_o == d0, "R6", "start aligned one clock later", data_o, d0);
    @(negedge clk);
    chk(!valid_o && !sof_o, "R6", "idle follows one clock later", {62'd0, valid_o, sof_o}, '0);
    for (int w = 1; w < 100; w++) begin
      @(negedge clk); valid = 1'b1; din = {$urandom, $urandom};
    end
    @(negedge clk); valid = 1'b0;
    chk(err_o == 0, "R7", "no error before restart", 64'(err_o), '0);
    fill_random(); send_row(0);
    chk(err_o == 1, "R7", "error after early start", 64'(err_o), 64'd1);
    check_row("R7", 0);
    fill_random(); send_row(0);
    chk(err_o == 1, "R7", "error stays set", 64'(err_o), 64'd1);
    check_row("R7", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle("pass before first start");
    t_random_row();
    t_gap_row();
    t_zero_row();
    t_idle("pass after row end");
    t_stuff();
    t_bypass();
    t_early();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule